// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Flag Unit

This unit sits next to a real-time clock's timekeeping chain. It holds three alarm bytes, one each for seconds, minutes and hours. When the clock reports that an update has finished, the unit compares the new time against these bytes and raises an alarm flag if all three fields agree. An alarm byte with both of its upper two bits set works as a wildcard and agrees with any value in its field.

The unit also records two other events: the end of each update and a periodic tick. Each of the three event flags is latched whether or not its source is enabled. A control byte holds one enable per source. The enables decide only whether a latched flag drives the summary bit and the active-low interrupt line. Software reads the flag byte to find the cause of an interrupt. That read returns the flags and clears them in the same access. An event that arrives in the cycle of the clearing read is kept for the next read.

The timekeeping counters, the periodic divider and the update sequencer are outside this unit. They supply the time bytes, a one-cycle update-done pulse and a one-cycle periodic pulse.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, the three alarm bytes, the control byte and the flag byte read as 0x00, and `irq_n_o` is high.
- R2: A write to index 1, 3 or 5 sets the seconds, minutes or hours alarm byte. A write to index 11 sets the control byte. Reads at these indices return the stored value.
- R3: In a cycle with `upd_done_i` high, bit 5 of the flag byte (index 12) is set on the next edge if every alarm byte matches its time input. If any byte fails to match, bit 5 is not set.
- R4: An alarm byte whose bits 7 and 6 are both 1 matches any time value. An alarm byte with only bit 7 set is compared exactly.
- R5: `upd_done_i` sets flag bit 4, and `per_pulse_i` sets flag bit 6, on the next edge.
- R6: Flag bits 6, 5 and 4 are set by their events whatever the control byte holds.
- R7: Flag bit 7 reads 1 exactly when some flag bit among 6, 5 and 4 is set and the control bit at the same position is also 1 (bit 6 periodic, bit 5 alarm, bit 4 update).
- R8: `irq_n_o` is low exactly when flag bit 7 would read 1. Once low, it stays low until the flag byte is read or the enables are changed.
- R9: A read of index 12 returns the flags as they were before the read. All flag bits are clear on the following cycle.
- R10: An event in the same cycle as a clearing read of index 12 is not lost. Its flag is set after that read.
- R11: Writes to index 12 have no effect. Reads of indices that are not used return 0x00.
- R12: The alarm flag is never set in a cycle without `upd_done_i`, even if the time inputs match the alarm bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_i | input | 8 | Current seconds value |
| min_i | input | 8 | Current minutes value |
| hr_i | input | 8 | Current hours value |
| upd_done_i | input | 1 | One-cycle pulse at the end of a time update |
| per_pulse_i | input | 1 | One-cycle periodic tick |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (a read of index 12 clears the flags) |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench goes after the wildcard boundary. A byte of 0x80 must still be compared exactly. A design that tested only bit 7 would raise alarms at the wrong time. The bench drives a periodic tick in the same cycle as a clearing read. A design that put the clear ahead of the set would lose that event, and the following read would return zero. The bench enables one source and fires a different one. It also holds a matching time without an update pulse. A design that gated the flags by their enables, or compared the time on every cycle, would show a wrong flag byte or a spurious interrupt.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
package rtc_irq_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NSRC = 3;

  localparam logic [AW-1:0] IDX_ALM_SEC = 4'd1;
  localparam logic [AW-1:0] IDX_ALM_MIN = 4'd3;
  localparam logic [AW-1:0] IDX_ALM_HR  = 4'd5;
  localparam logic [AW-1:0] IDX_CTRL    = 4'd11;
  localparam logic [AW-1:0] IDX_FLAG    = 4'd12;

  // source vector order: [2] periodic, [1] alarm, [0] update-ended
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;
  localparam int SRC_LSB = 4;   // source bits live at byte bits 6..4
  localparam int SUM_BIT = 7;

  function automatic logic [AW-1:0] alarm_index(input int n);
    case (n)
      0:       return IDX_ALM_SEC;
      1:       return IDX_ALM_MIN;
      default: return IDX_ALM_HR;
    endcase
  endfunction

  function automatic logic field_hit(input logic [DW-1:0] alm, input logic [DW-1:0] cur);
    return (alm[DW-1] & alm[DW-2]) | (alm == cur);
  endfunction

  function automatic logic [DW-1:0] flag_byte(input logic [NSRC-1:0] fl, input logic sum);
    logic [DW-1:0] b;
    b = '0;
    b[SRC_LSB +: NSRC] = fl;
    b[SUM_BIT] = sum;
    return b;
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
`timescale 1ns/1ps
module rtc_alarm_regs
  import rtc_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] sec,
  input  logic [DW-1:0] min,
  input  logic [DW-1:0] hr,
  output logic [DW-1:0] alm_sec,
  output logic [DW-1:0] alm_min,
  output logic [DW-1:0] alm_hr,
  output logic [DW-1:0] ctrl,
  output logic          time_hit
);
  localparam int NF = 3;

  logic [DW-1:0] alm_q [NF];
  logic [DW-1:0] cur   [NF];
  logic [NF-1:0] hit_v;

  assign cur[0] = sec;
  assign cur[1] = min;
  assign cur[2] = hr;

  for (genvar i = 0; i < NF; i++) begin : g_alm
    localparam logic [AW-1:0] MY_IDX = alarm_index(i);
    always_ff @(posedge clk) begin
      if (!rst_n)                     alm_q[i] <= '0;
      else if (we && addr == MY_IDX)  alm_q[i] <= wdata;
    end
    assign hit_v[i] = field_hit(alm_q[i], cur[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      ctrl <= '0;
    else if (we && addr == IDX_CTRL) ctrl <= wdata;
  end

  assign alm_sec  = alm_q[0];
  assign alm_min  = alm_q[1];
  assign alm_hr   = alm_q[2];
  assign time_hit = &hit_v;
endmodule

// File: rtl/rtc_flag_reg.sv
`timescale 1ns/1ps
module rtc_flag_reg
  import rtc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_ev,
  input  logic            clr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flags,
  output logic            sum
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= (flags[i] & ~clr) | set_ev[i];
    end
  end

  assign sum = |(flags & en);
endmodule

// File: rtl/rtc_irq_unit.sv
`timescale 1ns/1ps
module rtc_irq_unit
  import rtc_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    sec_i,
  input  logic [7:0]    min_i,
  input  logic [7:0]    hr_i,
  input  logic          upd_done_i,
  input  logic          per_pulse_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          irq_n_o
);
  logic [DW-1:0]   alm_sec_w, alm_min_w, alm_hr_w, ctrl_w;
  logic            time_hit_w;
  logic            alarm_evt_w;
  logic            flag_rd_w;
  logic [NSRC-1:0] set_w, en_w, flags_w;
  logic            sum_w;

  rtc_alarm_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we_i),
    .addr     (reg_addr_i),
    .wdata    (reg_wdata_i),
    .sec      (sec_i),
    .min      (min_i),
    .hr       (hr_i),
    .alm_sec  (alm_sec_w),
    .alm_min  (alm_min_w),
    .alm_hr   (alm_hr_w),
    .ctrl     (ctrl_w),
    .time_hit (time_hit_w)
  );

  assign alarm_evt_w    = upd_done_i & time_hit_w;
  assign flag_rd_w      = reg_re_i & (reg_addr_i == IDX_FLAG);
  assign set_w[SRC_UPD] = upd_done_i;
  assign set_w[SRC_ALM] = alarm_evt_w;
  assign set_w[SRC_PER] = per_pulse_i;
  assign en_w           = ctrl_w[SRC_LSB +: NSRC];

  rtc_flag_reg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (set_w),
    .clr    (flag_rd_w),
    .en     (en_w),
    .flags  (flags_w),
    .sum    (sum_w)
  );

  always_comb begin
    case (reg_addr_i)
      IDX_ALM_SEC: reg_rdata_o = alm_sec_w;
      IDX_ALM_MIN: reg_rdata_o = alm_min_w;
      IDX_ALM_HR:  reg_rdata_o = alm_hr_w;
      IDX_CTRL:    reg_rdata_o = ctrl_w;
      IDX_FLAG:    reg_rdata_o = flag_byte(flags_w, sum_w);
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_n_o = ~sum_w;
endmodule

// File: rtl/rtc_irq_chk.sv
`timescale 1ns/1ps
module rtc_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd,
  input logic       per,
  input logic       re,
  input logic       we,
  input logic [3:0] addr,
  input logic [2:0] flags,
  input logic [7:0] a_s,
  input logic [7:0] a_m,
  input logic [7:0] a_h,
  input logic       irq_n
);
  AST_UPD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flags[0]); // R5
  AST_PER_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    per |=> flags[2]); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr == 4'd12 && !upd && !per) |=> (flags == 3'b000)); // R9
  AST_ALARM_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(upd)); // R12
  AST_WILDCARD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && a_s[7:6] == 2'b11 && a_m[7:6] == 2'b11 && a_h[7:6] == 2'b11) |=> flags[1]); // R4
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(re && addr == 4'd12) && !(we && addr == 4'd11)) |=> !irq_n); // R8
  AST_KEEP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr == 4'd12 && per) |=> flags[2]); // R10
endmodule

bind rtc_irq_unit rtc_irq_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .upd   (upd_done_i),
  .per   (per_pulse_i),
  .re    (reg_re_i),
  .we    (reg_we_i),
  .addr  (reg_addr_i),
  .flags (flags_w),
  .a_s   (alm_sec_w),
  .a_m   (alm_min_w),
  .a_h   (alm_hr_w),
  .irq_n (irq_n_o)
);

// File: tb/sim_rtc_irq_unit.sv
`timescale 1ns/1ps
module sim_rtc_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sec_i = 8'h00, min_i = 8'h00, hr_i = 8'h00;
  logic       upd_done_i = 1'b0, per_pulse_i = 1'b0;
  logic       reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0] reg_addr_i = 4'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq_n_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .sec_i(sec_i), .min_i(min_i), .hr_i(hr_i),
    .upd_done_i(upd_done_i), .per_pulse_i(per_pulse_i),
    .reg_we_i(reg_we_i), .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_n_o(irq_n_o)
  );

  // behavioural reference model
  int m_alm [3];
  int m_ctrl;
  int m_flags;
  int nf;

  function automatic bit fits(int a, int v);
    return (a >= 192) || (a == v);
  endfunction

  function automatic bit m_sum();
    return (m_flags & m_ctrl & 'h70) != 0;
  endfunction

  function automatic int m_read(int a);
    if (a == 1) return m_alm[0];
    if (a == 3) return m_alm[1];
    if (a == 5) return m_alm[2];
    if (a == 11) return m_ctrl;
    if (a == 12) return m_flags + (m_sum() ? 128 : 0);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_alm[0] = 0; m_alm[1] = 0; m_alm[2] = 0; m_ctrl = 0; m_flags = 0;
    end else begin
      nf = m_flags;
      if (reg_re_i && reg_addr_i == 12) nf = 0;
      if (per_pulse_i) nf = nf | 'h40;
      if (upd_done_i) begin
        nf = nf | 'h10;
        if (fits(m_alm[0], sec_i) && fits(m_alm[1], min_i) && fits(m_alm[2], hr_i))
          nf = nf | 'h20;
      end
      if (reg_we_i) begin
        if (reg_addr_i == 1) m_alm[0] = reg_wdata_i;
        if (reg_addr_i == 3) m_alm[1] = reg_wdata_i;
        if (reg_addr_i == 5) m_alm[2] = reg_wdata_i;
        if (reg_addr_i == 11) m_ctrl = reg_wdata_i;
      end
      m_flags = nf;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 irq vs model", irq_n_o, m_sum() ? 0 : 1);
      if (reg_re_i) chk("R9 rdata vs model", reg_rdata_o, m_read(reg_addr_i));
    end
  end

  task automatic clear_in();
    upd_done_i = 0; per_pulse_i = 0; reg_we_i = 0; reg_re_i = 0;
  endtask

  task automatic idle();
    @(posedge clk); #2; clear_in();
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #2; clear_in();
    reg_we_i = 1; reg_addr_i = a[3:0]; reg_wdata_i = d[7:0];
  endtask

  task automatic rd(int a, int exp, string tag);
    @(posedge clk); #2; clear_in();
    reg_re_i = 1; reg_addr_i = a[3:0];
    @(negedge clk);
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic upd(int s, int m, int h);
    @(posedge clk); #2; clear_in();
    sec_i = s[7:0]; min_i = m[7:0]; hr_i = h[7:0]; upd_done_i = 1;
  endtask

  task automatic tick();
    @(posedge clk); #2; clear_in(); per_pulse_i = 1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R1 irq idle", irq_n_o, 1);
    rd(1, 0, "R1 alarm sec reset");
    rd(3, 0, "R1 alarm min reset");
    rd(5, 0, "R1 alarm hr reset");
    rd(11, 0, "R1 ctrl reset");
    rd(12, 0, "R1 flags reset");

    wr(1, 'h10); wr(3, 'h20); wr(5, 'h08); wr(11, 'h00);
    rd(1, 'h10, "R2 alarm sec");
    rd(3, 'h20, "R2 alarm min");
    rd(5, 'h08, "R2 alarm hr");

    upd('h10, 'h20, 'h08); idle();
    @(negedge clk); chk("R6 no irq when disabled", irq_n_o, 1);
    rd(12, 'h30, "R3 alarm match with update flag");
    rd(12, 'h00, "R9 flags cleared after read");

    upd('h11, 'h20, 'h08);
    rd(12, 'h10, "R3 seconds mismatch gives no alarm");

    @(posedge clk); #2; clear_in(); sec_i = 8'h10; min_i = 8'h20; hr_i = 8'h08;
    idle(); idle();
    rd(12, 'h00, "R12 matching time without update");

    wr(1, 'hC0); wr(3, 'hFF);
    upd('h37, 'h59, 'h08);
    rd(12, 'h30, "R4 wildcard bytes match");
    wr(1, 'h80);
    upd('h37, 'h59, 'h08);
    rd(12, 'h10, "R4 0x80 compared exactly");

    wr(11, 'h40);
    tick(); idle();
    @(negedge clk); chk("R8 irq low after enabled tick", irq_n_o, 0);
    rd(12, 'hC0, "R7 summary with periodic enabled");
    idle();
    @(negedge clk); chk("R8 irq released by read", irq_n_o, 1);

    wr(11, 'h20);
    tick(); idle();
    @(negedge clk); chk("R6 disabled source raises no irq", irq_n_o, 1);
    rd(12, 'h40, "R7 no summary for disabled source");

    wr(11, 'h10);
    upd('h00, 'h00, 'h00);
    repeat (5) idle();
    @(negedge clk); chk("R8 irq held until read", irq_n_o, 0);
    rd(12, 'h90, "R7 summary with update enabled");

    tick();
    @(posedge clk); #2; clear_in(); reg_re_i = 1; reg_addr_i = 4'd12; per_pulse_i = 1;
    @(negedge clk); chk("R10 read shows pre-event flags", reg_rdata_o, 'h40);
    rd(12, 'h40, "R10 coincident tick kept");

    tick();
    wr(12, 'hFF);
    rd(12, 'h40, "R11 write to flag byte ignored");
    rd(7, 'h00, "R11 unused index reads zero");
    rd(15, 'h00, "R11 top index reads zero");
    idle(); idle();

    done = 1;
    summary();
    $finish;
  end
endmodule